// File: doc/BRIEF.md
# Packed YUV to RGB line decoder

This block turns one line of packed 4:2:2 video source data into 24-bit RGB pixels for an overlay line buffer. The source is presented as a sequence of 32-bit groups. Each group holds two luma samples and one chroma pair, and yields two adjacent RGB pixels. A four-bit format code selects how the bytes are laid out in the group. One of the layouts takes its chroma from a separate source row, which arrives on a second 32-bit input that is indexed alongside the luma row.

A line starts with a single-cycle `start` pulse. The pulse samples the format code and the group count. The block then steps through the groups at one per clock and drives `src_idx`. The source data for that index must be present on `grp_data` and `uv_data` in the same cycle. One clock later, each group produces a registered write of an even/odd pair of line-buffer entries. Entries whose index falls outside the line buffer are not written. A format code the block does not recognise fills the line with magenta, so the fault can be seen on screen. The reset input is asynchronous and active low. Its release passes through two flops inside the block, so the block leaves reset two edges after `rst_n` rises.

Top module: `yuv_line_decoder`

## Requirements
- R1: The chroma bytes U and V are made signed by subtracting 128. The three offsets are floor((359·V)/256) for red, floor((88·U + 183·V)/256) for green and floor((453·U)/256) for blue, with floor taken towards minus infinity.
- R2: For each luma sample Y, the outputs are R = Y + red offset, G = Y − green offset and B = Y + blue offset. Each value is clamped to 0..255. A pixel is packed with R in bits [23:16], G in [15:8] and B in [7:0].
- R3: Format 4'hB reads, from byte 0 (`grp_data[7:0]`) up to byte 3: first luma, U, second luma, V.
- R4: Format 4'hC reads, from byte 0 up to byte 3: U, first luma, V, second luma.
- R5: Format 4'hA takes the first luma from `grp_data` byte 0 and the second luma from byte 1. It takes V from `uv_data` byte 2 (bits [23:16]) and U from `uv_data` byte 3 (bits [31:24]).
- R6: Any other format code writes 24'hFF00FF to both entries of every group.
- R7: While a line runs, `src_idx` steps 0, 1, … through the groups, one per clock. Group i is written one clock after it is indexed, to entry 2i (`lb_data0`, first luma) and entry 2i+1 (`lb_data1`, second luma), with `lb_addr` = 2i.
- R8: `done` is high for exactly one cycle, in the same cycle as the final pair is written. After that the block is idle. With a group count of zero, `done` is high in the cycle after `start` is sampled, and nothing is written.
- R9: `lb_we0` is low when entry 2i is at or beyond `LB_DEPTH`. `lb_we1` is low when entry 2i+1 is at or beyond `LB_DEPTH`. Each entry is judged on its own.
- R10: `start` has no effect while `busy` is high. The format code and group count are held from the accepted `start`, so changes on `fmt` and `width` during a line have no effect.
- R11: Once reset is released, `busy`, `done`, `lb_we0` and `lb_we1` are low until a `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal two-flop synchroniser |
| start | input | 1 | Begins a line when idle |
| fmt | input | 4 | Source format code, sampled at start |
| width | input | W_BITS | Number of source groups in the line, sampled at start |
| src_idx | output | W_BITS | Index of the group being read this cycle |
| grp_data | input | 32 | Packed group for `src_idx` (byte 0 in bits [7:0]) |
| uv_data | input | 32 | Group from the separate chroma row for `src_idx` |
| lb_we0 | output | 1 | Write enable for the even entry |
| lb_we1 | output | 1 | Write enable for the odd entry |
| lb_addr | output | W_BITS+1 | Even entry index; the odd entry is lb_addr+1 |
| lb_data0 | output | 24 | RGB pixel for the even entry |
| lb_data1 | output | 24 | RGB pixel for the odd entry |
| busy | output | 1 | A line is in progress, including its final cycle |
| done | output | 1 | One-cycle pulse with the final pair |

## Verification
The hardest case to reach is the buffer edge. There, one group has its even entry written and its odd entry suppressed. With the default depth this can never happen, because the group count is too narrow to reach the end of the buffer. The bench therefore builds the block with an odd, small `LB_DEPTH`, so a long line crosses the edge in the middle of a group. The clamping corners need chosen bytes: luma at 0 and 255 with chroma at 0 and 255 pushes every channel past both limits. Random bytes seldom land there. During every line the bench also pulses `start` again and changes `fmt` and `width`, to show that the sampled values are held.

// File: rtl/yuv_dec_pkg.sv
package yuv_dec_pkg;

  localparam logic [3:0]  FMT_YUV12_PK = 4'hA;
  localparam logic [3:0]  FMT_YUYV     = 4'hB;
  localparam logic [3:0]  FMT_UYVY     = 4'hC;
  localparam logic [23:0] FILL_RGB     = 24'hFF00FF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  // One unpacked source group: two luma samples plus a shared chroma pair
  typedef struct packed {
    logic [1:0][7:0] luma;
    logic [7:0]      cb;
    logic [7:0]      cr;
    logic            fill;
  } yuv_group_t;

endpackage

// File: rtl/yuv_fmt_unpack.sv
module yuv_fmt_unpack
  import yuv_dec_pkg::*;
(
  input  logic [3:0]  fmt,
  input  logic [31:0] grp_data,
  input  logic [31:0] uv_data,
  output yuv_group_t  grp
);

  logic [3:0][7:0] gb;
  logic [3:0][7:0] cb_row;
  logic [15:0]     unused_uv_low;

  assign gb            = grp_data;
  assign cb_row        = uv_data;
  assign unused_uv_low = uv_data[15:0];

  always_comb begin
    grp = '0;
    unique case (fmt)
      FMT_YUYV: begin
        grp.luma[0] = gb[0];
        grp.cb      = gb[1];
        grp.luma[1] = gb[2];
        grp.cr      = gb[3];
      end
      FMT_UYVY: begin
        grp.cb      = gb[0];
        grp.luma[0] = gb[1];
        grp.cr      = gb[2];
        grp.luma[1] = gb[3];
      end
      FMT_YUV12_PK: begin
        grp.luma[0] = gb[0];
        grp.luma[1] = gb[1];
        grp.cr      = cb_row[2];
        grp.cb      = cb_row[3];
      end
      default: begin
        grp.fill = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/yuv_chroma_offsets.sv
module yuv_chroma_offsets (
  input  logic [7:0]        cb,
  input  logic [7:0]        cr,
  output logic signed [9:0] off_r,
  output logic signed [9:0] off_g,
  output logic signed [9:0] off_b
);

  logic signed [8:0]  u_s;
  logic signed [8:0]  v_s;
  logic signed [17:0] prod_r;
  logic signed [17:0] prod_g;
  logic signed [17:0] prod_b;

  always_comb begin
    u_s    = $signed({1'b0, cb}) - 9'sd128;
    v_s    = $signed({1'b0, cr}) - 9'sd128;
    prod_r = 18'sd359 * v_s;
    prod_g = (18'sd88 * u_s) + (18'sd183 * v_s);
    prod_b = 18'sd453 * u_s;
    // upper bits of a two's complement product give the floor of /256
    off_r  = prod_r[17:8];
    off_g  = prod_g[17:8];
    off_b  = prod_b[17:8];
  end

endmodule

// File: rtl/yuv_pixel_clamp.sv
module yuv_pixel_clamp (
  input  logic [7:0]        luma,
  input  logic signed [9:0] off_r,
  input  logic signed [9:0] off_g,
  input  logic signed [9:0] off_b,
  output logic [23:0]       rgb
);

  logic signed [10:0] y_s;
  logic signed [10:0] sum_r;
  logic signed [10:0] sum_g;
  logic signed [10:0] sum_b;

  function automatic logic [7:0] sat8(input logic signed [10:0] v);
    if (v < 11'sd0)        return 8'd0;
    else if (v > 11'sd255) return 8'd255;
    else                   return v[7:0];
  endfunction

  always_comb begin
    y_s   = $signed({3'b000, luma});
    sum_r = y_s + $signed({off_r[9], off_r});
    sum_g = y_s - $signed({off_g[9], off_g});
    sum_b = y_s + $signed({off_b[9], off_b});
    rgb   = {sat8(sum_r), sat8(sum_g), sat8(sum_b)};
  end

endmodule

// File: rtl/yuv_line_seq.sv
module yuv_line_seq
  import yuv_dec_pkg::*;
#(
  parameter int W_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        fmt,
  input  logic [W_BITS-1:0] width,
  output logic [3:0]        fmt_q,
  output logic [W_BITS-1:0] grp_idx,
  output logic              grp_valid,
  output logic              busy,
  output logic              done
);

  seq_state_e        state_q, state_d;
  logic [W_BITS-1:0] cnt_q, cnt_d;
  logic [W_BITS-1:0] width_q, width_d;
  logic [3:0]        fmt_d;
  logic              accept;
  logic              last_grp;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    width_d  = width_q;
    fmt_d    = fmt_q;
    accept   = (state_q == ST_IDLE) && start;
    last_grp = (cnt_q == (width_q - W_BITS'(1)));
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          fmt_d   = fmt;
          width_d = width;
          cnt_d   = '0;
          state_d = (width == '0) ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + W_BITS'(1);
        if (last_grp) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      width_q <= '0;
      fmt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (accept) begin
        width_q <= width_d;
        fmt_q   <= fmt_d;
      end
    end
  end

  assign grp_idx   = cnt_q;
  assign grp_valid = (state_q == ST_RUN);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);

endmodule

// File: rtl/yuv_line_decoder.sv
module yuv_line_decoder
  import yuv_dec_pkg::*;
#(
  parameter int W_BITS   = 10,
  parameter int LB_DEPTH = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        fmt,
  input  logic [W_BITS-1:0] width,
  output logic [W_BITS-1:0] src_idx,
  input  logic [31:0]       grp_data,
  input  logic [31:0]       uv_data,
  output logic              lb_we0,
  output logic              lb_we1,
  output logic [W_BITS:0]   lb_addr,
  output logic [23:0]       lb_data0,
  output logic [23:0]       lb_data1,
  output logic              busy,
  output logic              done
);

  localparam int ADDR_W = W_BITS + 1;
  localparam int LANES  = 2;

  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [3:0]        fmt_q;
  logic [W_BITS-1:0] grp_idx;
  logic              grp_valid;

  yuv_line_seq #(.W_BITS(W_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start),
    .fmt       (fmt),
    .width     (width),
    .fmt_q     (fmt_q),
    .grp_idx   (grp_idx),
    .grp_valid (grp_valid),
    .busy      (busy),
    .done      (done)
  );

  assign src_idx = grp_idx;

  yuv_group_t grp;

  yuv_fmt_unpack u_unpack (
    .fmt      (fmt_q),
    .grp_data (grp_data),
    .uv_data  (uv_data),
    .grp      (grp)
  );

  logic signed [9:0] off_r, off_g, off_b;

  yuv_chroma_offsets u_offs (
    .cb    (grp.cb),
    .cr    (grp.cr),
    .off_r (off_r),
    .off_g (off_g),
    .off_b (off_b)
  );

  logic [LANES-1:0][23:0] px;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    yuv_pixel_clamp u_clamp (
      .luma  (grp.luma[ln]),
      .off_r (off_r),
      .off_g (off_g),
      .off_b (off_b),
      .rgb   (px[ln])
    );
  end

  // output stage: next-state
  logic [ADDR_W-1:0]      entry_even;
  logic [ADDR_W-1:0]      entry_odd;
  logic                   we0_d, we1_d;
  logic [LANES-1:0][23:0] data_d;

  always_comb begin
    entry_even = {grp_idx, 1'b0};
    entry_odd  = {grp_idx, 1'b1};
    we0_d      = grp_valid && (32'(entry_even) < 32'(LB_DEPTH));
    we1_d      = grp_valid && (32'(entry_odd)  < 32'(LB_DEPTH));
    data_d[0]  = grp.fill ? FILL_RGB : px[0];
    data_d[1]  = grp.fill ? FILL_RGB : px[1];
  end

  // output stage: registers; data loads only on a live group
  logic                   we0_q, we1_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [LANES-1:0][23:0] data_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      we0_q  <= 1'b0;
      we1_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we0_q <= we0_d;
      we1_q <= we1_d;
      if (grp_valid) begin
        addr_q <= entry_even;
        data_q <= data_d;
      end
    end
  end

  assign lb_we0   = we0_q;
  assign lb_we1   = we1_q;
  assign lb_addr  = addr_q;
  assign lb_data0 = data_q[0];
  assign lb_data1 = data_q[1];

endmodule

// File: rtl/yuv_line_decoder_chk.sv
module yuv_line_decoder_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lb_we0,
  input logic              lb_we1,
  input logic [ADDR_W-1:0] lb_addr,
  input logic              busy,
  input logic              done
);

  assert_pair_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lb_we1 |-> lb_we0);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_we0 && $past(lb_we0)) |-> (lb_addr == ($past(lb_addr) + ADDR_W'(2))));

  assert_write_in_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lb_we0 |-> busy);

endmodule

bind yuv_line_decoder yuv_line_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .lb_we0  (lb_we0),
  .lb_we1  (lb_we1),
  .lb_addr (lb_addr),
  .busy    (busy),
  .done    (done)
);

// File: tb/yuv_line_decoder_tb.sv
module yuv_line_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 63;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  fmt;
  logic [9:0]  width;
  logic [9:0]  src_idx;
  logic [31:0] grp_data, uv_data;
  logic        lb_we0, lb_we1, busy, done;
  logic [10:0] lb_addr;
  logic [23:0] lb_data0, lb_data1;

  logic [31:0] ymem  [0:1023];
  logic [31:0] uvmem [0:1023];

  int n_vec  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign grp_data = ymem[src_idx];
  assign uv_data  = uvmem[src_idx];

  yuv_line_decoder #(.W_BITS(10), .LB_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt), .width(width),
    .src_idx(src_idx), .grp_data(grp_data), .uv_data(uv_data),
    .lb_we0(lb_we0), .lb_we1(lb_we1), .lb_addr(lb_addr),
    .lb_data0(lb_data0), .lb_data1(lb_data1), .busy(busy), .done(done)
  );

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_px(int y, int u, int v);
    int uu = u - 128;
    int vv = v - 128;
    int dr = (359 * vv) >>> 8;
    int dg = (88 * uu + 183 * vv) >>> 8;
    int db = (453 * uu) >>> 8;
    int r = y + dr;
    int g = y - dg;
    int b = y + db;
    r = (r < 0) ? 0 : (r > 255) ? 255 : r;
    g = (g < 0) ? 0 : (g > 255) ? 255 : g;
    b = (b < 0) ? 0 : (b > 255) ? 255 : b;
    return {r[7:0], g[7:0], b[7:0]};
  endfunction

  // expected pair {even, odd} for group g under format f
  function automatic logic [47:0] ref_pair(logic [3:0] f, int g);
    logic [31:0] d = ymem[g];
    logic [31:0] c = uvmem[g];
    case (f)
      4'hB: return {ref_px(d[7:0],  d[15:8],  d[31:24]), ref_px(d[23:16], d[15:8],  d[31:24])};
      4'hC: return {ref_px(d[15:8], d[7:0],   d[23:16]), ref_px(d[31:24], d[7:0],   d[23:16])};
      4'hA: return {ref_px(d[7:0],  c[31:24], c[23:16]), ref_px(d[15:8],  c[31:24], c[23:16])};
      default: return {24'hFF00FF, 24'hFF00FF};
    endcase
  endfunction

  function automatic string fmt_req(logic [3:0] f);
    case (f)
      4'hB: return "R3/R1/R2";
      4'hC: return "R4/R1/R2";
      4'hA: return "R5/R1/R2";
      default: return "R6";
    endcase
  endfunction

  task automatic run_line(input logic [3:0] f, input int w);
    @(negedge clk);
    start = 1'b1; fmt = f; width = w[9:0];
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= w + 1; j++) begin
      if (j > 0) @(negedge clk);
      // R10: a second start and new fmt/width while busy must be ignored
      if (j == 1 && w >= 1) begin start = 1'b1; fmt = ~f; width = 10'd3; end
      if (j == 2) start = 1'b0;
      begin
        bit we0_e = (j >= 1) && (j <= w) && (2*(j-1)   < DEPTH);
        bit we1_e = (j >= 1) && (j <= w) && (2*(j-1)+1 < DEPTH);
        cmp("R8 busy",   {31'b0, busy}, {31'b0, (j <= w)});
        cmp("R8 done",   {31'b0, done}, {31'b0, (j == w)});
        cmp("R9/R7 we0", {31'b0, lb_we0}, {31'b0, we0_e});
        cmp("R9 we1",    {31'b0, lb_we1}, {31'b0, we1_e});
        if (we0_e) begin
          logic [47:0] ep = ref_pair(f, j-1);
          cmp("R7 addr", {21'b0, lb_addr}, 32'(2*(j-1)));
          cmp(fmt_req(f), {8'b0, lb_data0}, {8'b0, ep[47:24]});
          if (we1_e) cmp(fmt_req(f), {8'b0, lb_data1}, {8'b0, ep[23:0]});
        end
      end
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      ymem[i]  = $urandom;
      uvmem[i] = $urandom;
    end
    rst_n = 1'b0; start = 1'b0; fmt = 4'hB; width = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    cmp("R11 busy", {31'b0, busy},   32'd0);
    cmp("R11 done", {31'b0, done},   32'd0);
    cmp("R11 we0",  {31'b0, lb_we0}, 32'd0);
    cmp("R11 we1",  {31'b0, lb_we1}, 32'd0);

    run_line(4'hB, 8);   // R3
    run_line(4'hC, 5);   // R4
    run_line(4'hA, 6);   // R5
    // R2 clamp corners: luma at both ends, chroma at both ends
    ymem[0] = {8'hFF, 8'h00, 8'hFF, 8'h00};
    ymem[1] = {8'h00, 8'hFF, 8'h00, 8'hFF};
    ymem[2] = {8'h80, 8'h10, 8'h80, 8'hF0};
    ymem[3] = {8'h00, 8'h00, 8'hFF, 8'hFF};
    run_line(4'hB, 4);
    run_line(4'hC, 4);
    run_line(4'h3, 3);   // R6 unknown code
    run_line(4'hF, 2);   // R6
    run_line(4'hB, 0);   // R8 empty line
    run_line(4'hA, 1);   // R8 single group
    run_line(4'hB, 40);  // R9 crosses the buffer edge mid-group
    run_line(4'hC, 2);   // R10 block accepts a new line afterwards

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule